// File: doc/BRIEF.md
# Averaging ADC Sample Collector

This block gathers an averaged reading from an analog-to-digital converter that sits behind a register-read port inside a PHY. For each measurement it writes a tune-control word that picks what is measured. It then reads the converter's output register again and again. A response counts only when its status bit says the sample is valid. The first two valid samples are thrown away as warm-up. The next eighty valid samples are summed, and the sum is scaled to a milli-unit average. Each collection phase has a bounded number of read attempts. A phase that runs out of attempts stops early, keeps what it collected and raises an error flag.

In temperature mode the block runs two measurements back to back. The select bit of the tune word is clear for the first and set for the second. From the two averages it forms a difference ratio and evaluates a quadratic to get a temperature in milli-degrees. One shared sequential divider does every division, and each division truncates toward zero. A single-cycle done pulse comes with the final value.

Top module: `adcavg_top`

## Requirements
- R1: Each measurement starts with one write to address 0x0009. The data is the tune word given at start, with bit 4 forced to 0 for the first measurement and to 1 for the second, which only temperature mode issues.
- R2: Sample reads go to address 0x000A. A request stays asserted, with a stable address and direction, until the acknowledge cycle, and the read data is taken in that cycle.
- R3: A read word is a valid sample only when bit 10 is set, and its value is bits 9:0. An invalid word changes neither the valid count nor the sum.
- R4: The first two valid samples of a measurement are dropped and never reach the sum.
- R5: After the warm-up, exactly 80 valid samples are summed. The measurement equals sum*1000/80, truncated, and it is the result in single mode.
- R6: Warm-up and accumulation each have their own attempt count. If a phase has not reached its target after 201 reads, it ends, the error flag is set and the partial sum is kept. If the 201st read completes the target, the phase ends without error.
- R7: In temperature mode, with m1 taken at select 0 and m2 at select 1, a = (m2-m1)/(m2/1000) and the result is (-559*a*a)/1000 + 1379*a - 458000. All divisions truncate toward zero.
- R8: When m2/1000 is zero, m2 is replaced by 1000 and the divisor becomes 1.
- R9: done is high for exactly one cycle together with a new result. The error flag holds until the next accepted start, and a start raised while a run is in progress is ignored.
- R10: After reset no request is pending, and done, error and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| tempMode | input | 1 | 1: two-measurement temperature run, 0: single average |
| tuneWord | input | 16 | Tune-control word; bit 4 is replaced by the measurement select |
| busReq | output | 1 | Register port request |
| busWrite | output | 1 | Request is a write |
| busAddr | output | 16 | Register address |
| busWdata | output | 16 | Write data |
| busAck | input | 1 | Request completed this cycle |
| busRdata | input | 11 | Read data: bit 10 valid, bits 9:0 sample |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | An attempt limit was hit during the last run |
| result | output | 48 | Signed average or temperature in milli-units |

## Verification
On every cycle, the assertions check how the register port holds a request until it is acknowledged. They also check that invalid or warm-up reads leave the counters and the sum alone, that the attempt count never exceeds its cap, that the sum stays within its valid-count bound, that the divider never starts on a zero divisor or while busy, and that done stays a single-cycle pulse. The arithmetic itself can only be shown by the bench's scenarios, which compare against a reference computed from the requirements. That covers the discard-then-average result, the ordering of select values across the two writes, the exact read counts at the attempt limits including a target met on the last allowed read, the replacement of a tiny m2, the temperature value for both signs of the ratio, and the ignoring of a start raised mid-run.

// File: rtl/adcavg_pkg.sv
package adcavg_pkg;
  localparam int VAL_W     = 10;
  localparam int VALID_BIT = 10;
  localparam int SEL_BIT   = 4;
  localparam int SQ_COEF   = 559;
  localparam int LIN_COEF  = 1379;
  localparam int OFFSET    = 458000;

  typedef enum logic [1:0] {OP_AVG, OP_M2, OP_RATIO, OP_TEMP} divOpT;

  typedef enum logic [3:0] {
    S_IDLE, S_WRITE, S_WARM_RD, S_WARM_CHK, S_ACC_RD, S_ACC_CHK,
    S_DIV_GO, S_DIV_WAIT, S_FIN
  } stateT;

  typedef struct packed {
    logic  phaseClr;
    logic  sampleTake;
    logic  accumPhase;
    logic  measSel;
    logic  useTemp;
    logic  divStart;
    divOpT divOp;
    logic  finish;
  } strobeT;
endpackage

// File: rtl/adcavg_div.sv
module adcavg_div #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] numer,
  input  logic signed [W-1:0] denom,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  work;
  logic [W-1:0]  dAbs;
  logic [W-1:0]  rem;
  logic          qNeg;
  logic [CW-1:0] cnt;
  logic [W:0]    remTry;
  logic [W:0]    diff;

  assign remTry = {rem, work[W-1]};
  assign diff   = remTry - {1'b0, dAbs};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work <= '0;
      dAbs <= '0;
      rem  <= '0;
      qNeg <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        work <= numer[W-1] ? (~numer + 1'b1) : numer;
        dAbs <= denom[W-1] ? (~denom + 1'b1) : denom;
        qNeg <= numer[W-1] ^ denom[W-1];
        rem  <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          rem  <= diff[W-1:0];
          work <= {work[W-2:0], 1'b1};
        end else begin
          rem  <= remTry[W-1:0];
          work <= {work[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = qNeg ? -$signed(work) : $signed(work);

  // R8: the divisor is never zero when a division begins
  p_den_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |-> denom != '0);
  // R7: completion is only flagged once iterations have stopped
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/adcavg_ctrl.sv
module adcavg_ctrl
  import adcavg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] TUNE_ADDR = 16'h0009,
  parameter logic [15:0] ADC_ADDR  = 16'h000A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              tempMode,
  input  logic [DATA_W-1:0] tuneWord,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic              targetHit,
  input  logic              limitHit,
  input  logic              divDone,
  output strobeT            strb,
  output logic              done,
  output logic              error
);
  stateT             state;
  logic              measSel;
  logic              useTemp;
  logic [DATA_W-1:0] tuneHeld;
  divOpT             divOpR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      measSel  <= 1'b0;
      useTemp  <= 1'b0;
      tuneHeld <= '0;
      divOpR   <= OP_AVG;
      error    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          measSel  <= 1'b0;
          useTemp  <= tempMode;
          tuneHeld <= tuneWord;
          error    <= 1'b0;
          divOpR   <= OP_AVG;
          state    <= S_WRITE;
        end
        S_WRITE:   if (busAck) state <= S_WARM_RD;
        S_WARM_RD: if (busAck) state <= S_WARM_CHK;
        S_WARM_CHK: begin
          if (targetHit) state <= S_ACC_RD;
          else if (limitHit) begin
            error <= 1'b1;
            state <= S_ACC_RD;
          end else state <= S_WARM_RD;
        end
        S_ACC_RD: if (busAck) state <= S_ACC_CHK;
        S_ACC_CHK: begin
          divOpR <= OP_AVG;
          if (targetHit) state <= S_DIV_GO;
          else if (limitHit) begin
            error <= 1'b1;
            state <= S_DIV_GO;
          end else state <= S_ACC_RD;
        end
        S_DIV_GO: state <= S_DIV_WAIT;
        S_DIV_WAIT: if (divDone) begin
          case (divOpR)
            OP_AVG: begin
              if (useTemp && !measSel) begin
                measSel <= 1'b1;
                state   <= S_WRITE;
              end else if (useTemp) begin
                divOpR <= OP_M2;
                state  <= S_DIV_GO;
              end else state <= S_FIN;
            end
            OP_M2: begin
              divOpR <= OP_RATIO;
              state  <= S_DIV_GO;
            end
            OP_RATIO: begin
              divOpR <= OP_TEMP;
              state  <= S_DIV_GO;
            end
            default: state <= S_FIN;
          endcase
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.measSel  = measSel;
    strb.useTemp  = useTemp;
    strb.divOp    = divOpR;
    busReq        = 1'b0;
    busWrite      = 1'b0;
    busAddr       = ADDR_W'(ADC_ADDR);
    busWdata      = tuneHeld;
    busWdata[SEL_BIT] = measSel;
    case (state)
      S_WRITE: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        busAddr  = ADDR_W'(TUNE_ADDR);
        strb.phaseClr = busAck;
      end
      S_WARM_RD: begin
        busReq = 1'b1;
        strb.sampleTake = busAck;
      end
      S_WARM_CHK: strb.phaseClr = targetHit || limitHit;
      S_ACC_RD: begin
        busReq = 1'b1;
        strb.accumPhase = 1'b1;
        strb.sampleTake = busAck;
      end
      S_ACC_CHK:  strb.accumPhase = 1'b1;
      S_DIV_GO:   strb.divStart = 1'b1;
      S_FIN:      strb.finish = 1'b1;
      default: ;
    endcase
  end

  // R2: a request holds its address and direction until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite));
  // R1: the second select value is only written in temperature mode
  p_sel_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWrite && busWdata[SEL_BIT] |-> useTemp);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: no register traffic accompanies completion
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq);
endmodule

// File: rtl/adcavg_dp.sv
module adcavg_dp
  import adcavg_pkg::*;
#(
  parameter int DISCARD = 2,
  parameter int SAMPLES = 80,
  parameter int LIMIT   = 200,
  parameter int SCALE   = 1000,
  parameter int DIV_W   = 64,
  parameter int RES_W   = 48
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strb,
  input  logic [VALID_BIT:0]      rdWord,
  output logic                    targetHit,
  output logic                    limitHit,
  output logic                    divDone,
  output logic signed [RES_W-1:0] result
);
  localparam int MAX_VAL = (1 << VAL_W) - 1;
  localparam int ACC_W   = $clog2(SAMPLES * MAX_VAL + 1);
  localparam int CNT_W   = $clog2(SAMPLES + 1);
  localparam int ATT_W   = $clog2(LIMIT + 2);
  localparam logic signed [DIV_W-1:0] kScale   = DIV_W'(SCALE);
  localparam logic signed [DIV_W-1:0] kSamples = DIV_W'(SAMPLES);
  localparam logic signed [DIV_W-1:0] kSq      = DIV_W'(SQ_COEF);
  localparam logic signed [DIV_W-1:0] kLin     = DIV_W'(LIN_COEF);
  localparam logic signed [DIV_W-1:0] kOff     = DIV_W'(OFFSET);

  logic [ATT_W-1:0] attemptCnt;
  logic [CNT_W-1:0] validCnt;
  logic [ACC_W-1:0] accum;
  logic signed [DIV_W-1:0] mFirst, mSecond, m2Div, aReg, sqQuot;
  logic signed [DIV_W-1:0] accWide, divNum, divDen, quot;
  logic divBusy;
  logic sampleValid;

  assign sampleValid = rdWord[VALID_BIT];
  assign accWide     = {{(DIV_W-ACC_W){1'b0}}, accum};
  assign targetHit   = validCnt == (strb.accumPhase ? CNT_W'(SAMPLES) : CNT_W'(DISCARD));
  assign limitHit    = attemptCnt > ATT_W'(LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attemptCnt <= '0;
      validCnt   <= '0;
      accum      <= '0;
    end else if (strb.phaseClr) begin
      attemptCnt <= '0;
      validCnt   <= '0;
      accum      <= '0;
    end else if (strb.sampleTake) begin
      attemptCnt <= attemptCnt + 1'b1;
      if (sampleValid) begin
        validCnt <= validCnt + 1'b1;
        if (strb.accumPhase) accum <= accum + ACC_W'(rdWord[VAL_W-1:0]);
      end
    end
  end

  always_comb begin
    case (strb.divOp)
      OP_AVG:   begin divNum = accWide * kScale;  divDen = kSamples; end
      OP_M2:    begin divNum = mSecond;           divDen = kScale;   end
      OP_RATIO: begin divNum = mSecond - mFirst;  divDen = m2Div;    end
      default:  begin divNum = kSq * aReg * aReg; divDen = kScale;   end
    endcase
  end

  adcavg_div #(.W(DIV_W)) uDiv (
    .clk   (clk),
    .rstN  (rstN),
    .start (strb.divStart),
    .numer (divNum),
    .denom (divDen),
    .busy  (divBusy),
    .done  (divDone),
    .quot  (quot)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFirst  <= '0;
      mSecond <= '0;
      m2Div   <= '0;
      aReg    <= '0;
      sqQuot  <= '0;
      result  <= '0;
    end else begin
      if (divDone) begin
        case (strb.divOp)
          OP_AVG: if (strb.measSel) mSecond <= quot; else mFirst <= quot;
          OP_M2: begin
            if (quot == '0) begin
              m2Div   <= DIV_W'(1);
              mSecond <= kScale;
            end else m2Div <= quot;
          end
          OP_RATIO: aReg   <= quot;
          default:  sqQuot <= quot;
        endcase
      end
      if (strb.finish)
        result <= strb.useTemp ? RES_W'(kLin * aReg - sqQuot - kOff) : RES_W'(mFirst);
    end
  end

  // R3: an invalid response leaves the count and the sum untouched
  p_invalid_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleTake && !sampleValid |=> $stable(validCnt) && $stable(accum));
  // R4: warm-up samples never reach the sum
  p_warm_discard_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleTake && !strb.accumPhase |=> $stable(accum));
  // R5: the sum cannot exceed the full-scale value times the valid count
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    accum <= ACC_W'(validCnt) * ACC_W'(MAX_VAL));
  // R6: a phase never makes more than one read past the limit
  p_attempt_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt <= ATT_W'(LIMIT + 1));
  // R7: the shared divider is never restarted while iterating
  p_div_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.divStart |-> !divBusy);
endmodule

// File: rtl/adcavg_top.sv
module adcavg_top
  import adcavg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] TUNE_ADDR = 16'h0009,
  parameter logic [15:0] ADC_ADDR  = 16'h000A,
  parameter int          DISCARD   = 2,
  parameter int          SAMPLES   = 80,
  parameter int          LIMIT     = 200,
  parameter int          SCALE     = 1000,
  parameter int          DIV_W     = 64,
  parameter int          RES_W     = 48
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    tempMode,
  input  logic [DATA_W-1:0]       tuneWord,
  output logic                    busReq,
  output logic                    busWrite,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busWdata,
  input  logic                    busAck,
  input  logic [VALID_BIT:0]      busRdata,
  output logic                    done,
  output logic                    error,
  output logic signed [RES_W-1:0] result
);
  strobeT strb;
  logic   targetHit;
  logic   limitHit;
  logic   divDone;

  adcavg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TUNE_ADDR(TUNE_ADDR), .ADC_ADDR(ADC_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .tempMode(tempMode), .tuneWord(tuneWord),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .targetHit(targetHit), .limitHit(limitHit), .divDone(divDone),
    .strb(strb), .done(done), .error(error)
  );

  adcavg_dp #(
    .DISCARD(DISCARD), .SAMPLES(SAMPLES), .LIMIT(LIMIT), .SCALE(SCALE),
    .DIV_W(DIV_W), .RES_W(RES_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdWord(busRdata),
    .targetHit(targetHit), .limitHit(limitHit), .divDone(divDone), .result(result)
  );
endmodule

// File: tb/tb_adcavg_top.sv
module tb_adcavg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        tempMode = 1'b0;
  logic [15:0] tuneWord = '0;
  logic        busReq, busWrite;
  logic [15:0] busAddr, busWdata;
  logic        busAck;
  logic [10:0] busRdata;
  logic        done, error;
  logic signed [47:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int patCur = 0;
  logic [15:0] tuneCur = '0;
  int writes = 0, wrBad = 0, rdBad = 0, doneCnt = 0, kIdx = 0;
  int reads [2];

  always #10 clk = ~clk;

  adcavg_top dut (
    .clk(clk), .rstN(rstN), .start(start), .tempMode(tempMode), .tuneWord(tuneWord),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .done(done), .error(error), .result(result)
  );

  function automatic logic [10:0] sampleWord(input int pat, input int meas, input int k);
    case (pat)
      0: return {1'b1, 10'((k * 37 + meas * 101) % 1024)};
      1: return 11'h7FF;
      2: return (k % 3 == 2) ? 11'h3FF : {1'b1, 10'((k * 13) % 1024)};
      3: return (k < 201) ? 11'h3FF : {1'b1, 10'(k % 1024)};
      4: return (k % 4 == 0) ? {1'b1, 10'((k * 5) % 1024)} : 11'h000;
      5: return (k < 199) ? 11'h155 : {1'b1, 10'd500};
      6: return {1'b1, (meas == 0) ? 10'd600 : 10'd300};
      7: return {1'b1, (meas == 1 && k == 10) ? 10'd50 : 10'd0};
      8: return {1'b1, (meas == 1) ? 10'd1023 : 10'((k * 7) % 512)};
      default: return 11'h000;
    endcase
  endfunction

  // Reference per requirements R3 to R6
  function automatic longint refMeas(input int pat, input int meas, output bit err, output int nRd);
    int k = 0;
    int cnt = 0;
    int att = 0;
    longint sum = 0;
    logic [10:0] w;
    err = 0;
    while (1) begin
      w = sampleWord(pat, meas, k); k++; att++;
      if (w[10]) cnt++;
      if (cnt == 2) break;
      if (att > 200) begin err = 1; break; end
    end
    cnt = 0; att = 0;
    while (1) begin
      w = sampleWord(pat, meas, k); k++; att++;
      if (w[10]) begin cnt++; sum += longint'(w[9:0]); end
      if (cnt == 80) break;
      if (att > 200) begin err = 1; break; end
    end
    nRd = k;
    return (sum * 1000) / 80;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Register port responder
  initial begin
    busAck = 1'b0;
    busRdata = '0;
    forever begin
      @(negedge clk);
      if (done) doneCnt++;
      if (busReq && !busAck) begin
        if (busWrite) begin
          logic [15:0] expW;
          expW = tuneCur;
          expW[4] = (writes != 0);
          if (busAddr !== 16'h0009 || busWdata !== expW) wrBad++;
          writes++;
          kIdx = 0;
          busRdata = '0;
        end else begin
          if (busAddr !== 16'h000A) rdBad++;
          busRdata = sampleWord(patCur, writes - 1, kIdx);
          kIdx++;
          if (writes >= 1 && writes <= 2) reads[writes-1]++;
        end
        busAck = 1'b1;
      end else begin
        busAck = 1'b0;
      end
    end
  end

  task automatic runCase(input int pat, input bit temp, input logic [15:0] tune,
                         input bit intrude, input string tag);
    bit e1, e2;
    int r1, r2;
    longint m1, m2, m2d, a, expRes;
    logic signed [47:0] exp48;
    bit expErr;
    patCur = pat; tuneCur = tune;
    writes = 0; wrBad = 0; rdBad = 0; doneCnt = 0;
    reads[0] = 0; reads[1] = 0;
    e2 = 0; r2 = 0;
    m1 = refMeas(pat, 0, e1, r1);
    if (temp) begin
      m2 = refMeas(pat, 1, e2, r2);
      m2d = m2 / 1000;
      if (m2d == 0) begin m2 = 1000; m2d = 1; end
      a = (m2 - m1) / m2d;
      expRes = ((-559) * a * a) / 1000 + 1379 * a - 458000;
    end else expRes = m1;
    expErr = e1 | e2;
    exp48 = expRes[47:0];
    @(negedge clk); start = 1'b1; tempMode = temp; tuneWord = tune;
    @(negedge clk); start = 1'b0;
    if (intrude) begin
      repeat (30) @(negedge clk);
      start = 1'b1; tempMode = !temp; tuneWord = ~tune;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(result === exp48, tag, longint'(result), longint'(exp48));
    chk(error === expErr, "R6", longint'(error), longint'(expErr));
    @(negedge clk);
    chk(done === 1'b0, "R9", longint'(done), 0);
    repeat (3) @(negedge clk);
    chk(error === expErr, "R9", longint'(error), longint'(expErr));
    chk(doneCnt == 1, "R9", doneCnt, 1);
    chk(writes == (temp ? 2 : 1) && wrBad == 0, "R1", writes * 100 + wrBad, (temp ? 2 : 1) * 100);
    chk(rdBad == 0 && reads[0] == r1 && reads[1] == r2, "R2",
        reads[0] * 1000 + reads[1], r1 * 1000 + r2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busReq === 1'b0 && done === 1'b0 && error === 1'b0 && result === '0,
        "R10", longint'({busReq, done, error}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runCase(0, 1'b0, 16'h0000, 1'b0, "R4");
    runCase(1, 1'b0, 16'hFFFF, 1'b0, "R5");
    runCase(2, 1'b0, 16'h1234, 1'b0, "R3");
    runCase(3, 1'b0, 16'h00EF, 1'b0, "R6");
    runCase(4, 1'b0, 16'h0010, 1'b0, "R6");
    runCase(5, 1'b0, 16'h5A5A, 1'b0, "R6");
    runCase(6, 1'b1, 16'h0009, 1'b0, "R7");
    runCase(7, 1'b1, 16'hFFEF, 1'b0, "R8");
    runCase(8, 1'b1, 16'h0F0F, 1'b0, "R7");
    runCase(2, 1'b1, 16'h8001, 1'b0, "R3");
    runCase(0, 1'b0, 16'h0033, 1'b1, "R9");
    runCase(4, 1'b1, 16'h7777, 1'b0, "R6");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule